// File: doc/BRIEF.md
# Bank-Aware Request Reorder Queue

This block sits in front of a DRAM-style memory built from bank groups, banks and rows. It holds pending read and write requests and, on every cycle that the downstream side is ready, hands out the one request that is best to issue next. Each request carries a tag (transaction ID), a direction, a bank group, a bank, a row and a column. The selected request comes out together with two flags: whether its bank must first be precharged, and whether it must first be activated. The queue tracks the open row of every bank itself.

The choice favours row-buffer locality first. It then alternates bank groups, then prefers banks that are idle over banks holding another row, and then keeps the current read or write direction. The oldest request wins any remaining tie. An age count per entry bounds how long a request can be bypassed. Requests that share a tag always leave in arrival order. An optional mode extends that ordering to all requests that hit the same bank and row. A second optional mode closes the page after every access. Timing parameters, the command bus and data movement belong to the surrounding controller.

Top module: `bank_reorder_queue`

## Requirements
- R1: Out of reset the queue is empty, `out_valid` is 0, `in_ready` is 1, and every bank is closed. No request has been issued yet, so no request counts as a bank-group change and the read direction (`in_write`=0) counts as the current direction.
- R2: An eligible request whose bank holds its row open is chosen ahead of every request that does not, unless a starved request is pending.
- R3: If no other rule decides, a request to a bank group other than the one last issued is chosen ahead of one to the same bank group.
- R4: If no other rule decides, a request to an idle bank is chosen ahead of one to a bank holding another row. `out_need_act` is 1 unless the bank holds the request's row. `out_need_pre` is 1 only when the bank holds a different row.
- R5: Requests with equal `in_id` are issued in the order they were accepted, whatever their priority.
- R6: With `cfg_coherent`=1, requests to the same bank group, bank and row are issued in acceptance order, whatever their IDs. With it 0, they may pass each other.
- R7: With `cfg_closed_page`=1, every issued request shows `out_autopre`=1, and its bank is closed afterwards, so the next request to it needs an activate and no precharge.
- R8: If no other rule decides, a request in the direction of the last issued request is chosen ahead of one in the other direction.
- R9: Each entry counts the requests accepted after it that were issued before it. Once that count reaches `cfg_age_limit`, the entry outranks every non-starved entry.
- R10: Requests of equal rank leave oldest first.
- R11: `in_ready` is 0 exactly when the queue holds DEPTH entries. A request offered then is not stored. Each accept adds one entry and each issue (`out_valid` and `out_ready`) removes one.
- R12: The open-row table is written at the clock edge that issues a request. The next choice already sees the issued row as open, or as closed in closed-page mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_coherent | input | 1 | Keep arrival order among requests to the same bank and row |
| cfg_closed_page | input | 1 | Close the page after every access |
| cfg_age_limit | input | AGE_W | Bypass count at which an entry is starved (128 typical) |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue has space |
| in_id | input | ID_W | Transaction ID |
| in_write | input | 1 | 1 = write, 0 = read |
| in_bg | input | BG_W | Bank group |
| in_bank | input | BK_W | Bank within the group |
| in_row | input | ROW_W | Row |
| in_col | input | COL_W | Column |
| out_valid | output | 1 | A request is selected |
| out_ready | input | 1 | Downstream takes the selected request this cycle |
| out_id | output | ID_W | Selected ID |
| out_write | output | 1 | Selected direction |
| out_bg | output | BG_W | Selected bank group |
| out_bank | output | BK_W | Selected bank |
| out_row | output | ROW_W | Selected row |
| out_col | output | COL_W | Selected column |
| out_need_pre | output | 1 | Bank holds another row and must be precharged |
| out_need_act | output | 1 | Row must be activated before access |
| out_autopre | output | 1 | Access closes the page |

## Verification
The assertions assume that the configuration inputs hold steady while requests are pending. They also assume that `in_valid` is never X after reset and that a request offered while the queue is full is ignored and not queued. The stimulus changes configuration only inside a reset and drives every input from its first cycle. Each scenario starts from a fresh reset, so the last-issued bank group and direction are known. Each scenario also fills the queue with `out_ready` low before it drains, so every choice is made among a known set of entries.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;
  localparam int RANK_W = 6;

  // Rank of one entry: higher value wins, ineligible entries rank zero.
  function automatic logic [RANK_W-1:0] rank_of(input logic elig, input logic starved,
                                               input logic hit, input logic alt_bg,
                                               input logic idle, input logic same_dir);
    rank_of = elig ? {1'b1, starved, hit, alt_bg, idle, same_dir} : '0;
  endfunction
endpackage

// File: rtl/rq_row_table.sv
`timescale 1ns/1ps
module rq_row_table #(
  parameter int BG_W = 2,
  parameter int BK_W = 2,
  parameter int ROW_W = 14,
  localparam int BIX_W = BG_W + BK_W,
  localparam int NBANK = 1 << BIX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            upd,
  input  logic [BIX_W-1:0]                upd_bank,
  input  logic [ROW_W-1:0]                upd_row,
  input  logic                            upd_close,
  output logic [NBANK-1:0]                open_vld,
  output logic [NBANK-1:0][ROW_W-1:0]     open_row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld <= '0;
      open_row <= '0;
    end else if (upd) begin
      open_vld[upd_bank] <= !upd_close;
      open_row[upd_bank] <= upd_row;
    end
  end
endmodule

// File: rtl/rq_picker.sv
`timescale 1ns/1ps
module rq_picker import rq_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int ID_W = 6,
  parameter int BG_W = 2,
  parameter int BK_W = 2,
  parameter int ROW_W = 14,
  parameter int AGE_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NBANK = 1 << (BG_W + BK_W)
) (
  input  logic [CNT_W-1:0]              count,
  input  logic [DEPTH-1:0][ID_W-1:0]    f_id,
  input  logic [DEPTH-1:0]              f_wr,
  input  logic [DEPTH-1:0][BG_W-1:0]    f_bg,
  input  logic [DEPTH-1:0][BK_W-1:0]    f_bk,
  input  logic [DEPTH-1:0][ROW_W-1:0]   f_row,
  input  logic [DEPTH-1:0][AGE_W-1:0]   f_age,
  input  logic [NBANK-1:0]              open_vld,
  input  logic [NBANK-1:0][ROW_W-1:0]   open_row,
  input  logic                          last_vld,
  input  logic [BG_W-1:0]               last_bg,
  input  logic                          last_wr,
  input  logic                          cfg_coherent,
  input  logic [AGE_W-1:0]              cfg_age_limit,
  output logic [IDX_W-1:0]              pick_idx,
  output logic                          any_hit_elig,
  output logic                          any_starved_elig
);
  logic [DEPTH-1:0]             blk, elig, hit, starved;
  logic [DEPTH-1:0][RANK_W-1:0] rk;
  logic [RANK_W-1:0]            best;

  always_comb begin
    any_hit_elig = 1'b0;
    any_starved_elig = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (f_id[j] == f_id[i]) blk[i] = 1'b1;
        if (cfg_coherent && f_bg[j] == f_bg[i] && f_bk[j] == f_bk[i] && f_row[j] == f_row[i])
          blk[i] = 1'b1;
      end
      elig[i]    = (CNT_W'(i) < count) && !blk[i];
      hit[i]     = open_vld[{f_bg[i], f_bk[i]}] && (open_row[{f_bg[i], f_bk[i]}] == f_row[i]);
      starved[i] = f_age[i] >= cfg_age_limit;
      rk[i] = rank_of(elig[i], starved[i], hit[i], last_vld && (f_bg[i] != last_bg),
                      !open_vld[{f_bg[i], f_bk[i]}], f_wr[i] == last_wr);
      any_hit_elig     = any_hit_elig | (elig[i] & hit[i]);
      any_starved_elig = any_starved_elig | (elig[i] & starved[i]);
    end
    best = rk[0];
    pick_idx = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (rk[i] > best) begin
        best = rk[i];
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bank_reorder_queue.sv
`timescale 1ns/1ps
module bank_reorder_queue #(
  parameter int DEPTH = 64,
  parameter int ID_W = 6,
  parameter int BG_W = 2,
  parameter int BK_W = 2,
  parameter int ROW_W = 14,
  parameter int COL_W = 5,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_coherent,
  input  logic             cfg_closed_page,
  input  logic [AGE_W-1:0] cfg_age_limit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic             in_write,
  input  logic [BG_W-1:0]  in_bg,
  input  logic [BK_W-1:0]  in_bank,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_id,
  output logic             out_write,
  output logic [BG_W-1:0]  out_bg,
  output logic [BK_W-1:0]  out_bank,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic             out_need_pre,
  output logic             out_need_act,
  output logic             out_autopre
);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int BIX_W  = BG_W + BK_W;
  localparam int NBANK  = 1 << BIX_W;
  localparam int O_ROW  = COL_W;
  localparam int O_BK   = O_ROW + ROW_W;
  localparam int O_BG   = O_BK + BK_W;
  localparam int O_WR   = O_BG + BG_W;
  localparam int O_ID   = O_WR + 1;
  localparam int ENT_W  = O_ID + ID_W;

  // entry storage, index 0 is the oldest
  logic [DEPTH-1:0][ENT_W-1:0] q_ent, up_ent;
  logic [DEPTH-1:0][AGE_W-1:0] q_age, up_age;
  logic [CNT_W-1:0]            count;

  logic [DEPTH-1:0][ID_W-1:0]  f_id;
  logic [DEPTH-1:0]            f_wr;
  logic [DEPTH-1:0][BG_W-1:0]  f_bg;
  logic [DEPTH-1:0][BK_W-1:0]  f_bk;
  logic [DEPTH-1:0][ROW_W-1:0] f_row;
  logic [DEPTH-1:0][COL_W-1:0] f_col;

  // named internal events
  logic              accept, fire;
  logic [IDX_W-1:0]  pick_idx;
  logic [CNT_W-1:0]  wr_pos;
  logic              any_hit_elig, any_starved_elig, pick_hit;
  logic [BIX_W-1:0]  pick_bank;
  logic              last_vld, last_wr;
  logic [BG_W-1:0]   last_bg;
  logic [NBANK-1:0]            open_vld;
  logic [NBANK-1:0][ROW_W-1:0] open_row;
  logic [ENT_W-1:0]  new_ent;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign f_col[g] = q_ent[g][0 +: COL_W];
    assign f_row[g] = q_ent[g][O_ROW +: ROW_W];
    assign f_bk[g]  = q_ent[g][O_BK +: BK_W];
    assign f_bg[g]  = q_ent[g][O_BG +: BG_W];
    assign f_wr[g]  = q_ent[g][O_WR];
    assign f_id[g]  = q_ent[g][O_ID +: ID_W];
    if (g < DEPTH - 1) begin : g_up
      assign up_ent[g] = q_ent[g+1];
      assign up_age[g] = q_age[g+1];
    end else begin : g_top
      assign up_ent[g] = q_ent[g];
      assign up_age[g] = q_age[g];
    end
  end

  assign in_ready  = count < CNT_W'(DEPTH);
  assign out_valid = count != '0;
  assign accept    = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign wr_pos    = count - CNT_W'(fire);
  assign new_ent   = {in_id, in_write, in_bg, in_bank, in_row, in_col};

  rq_picker #(.DEPTH(DEPTH), .ID_W(ID_W), .BG_W(BG_W), .BK_W(BK_W), .ROW_W(ROW_W),
              .AGE_W(AGE_W)) u_pick (
    .count(count), .f_id(f_id), .f_wr(f_wr), .f_bg(f_bg), .f_bk(f_bk), .f_row(f_row),
    .f_age(q_age), .open_vld(open_vld), .open_row(open_row), .last_vld(last_vld),
    .last_bg(last_bg), .last_wr(last_wr), .cfg_coherent(cfg_coherent),
    .cfg_age_limit(cfg_age_limit), .pick_idx(pick_idx), .any_hit_elig(any_hit_elig),
    .any_starved_elig(any_starved_elig));

  assign out_id    = f_id[pick_idx];
  assign out_write = f_wr[pick_idx];
  assign out_bg    = f_bg[pick_idx];
  assign out_bank  = f_bk[pick_idx];
  assign out_row   = f_row[pick_idx];
  assign out_col   = f_col[pick_idx];
  assign pick_bank = {out_bg, out_bank};
  assign pick_hit  = open_vld[pick_bank] && (open_row[pick_bank] == out_row);
  assign out_need_act = !pick_hit;
  assign out_need_pre = open_vld[pick_bank] && !pick_hit;
  assign out_autopre  = cfg_closed_page;

  rq_row_table #(.BG_W(BG_W), .BK_W(BK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .upd(fire), .upd_bank(pick_bank), .upd_row(out_row),
    .upd_close(cfg_closed_page), .open_vld(open_vld), .open_row(open_row));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      q_ent    <= '0;
      q_age    <= '0;
      last_vld <= 1'b0;
      last_bg  <= '0;
      last_wr  <= 1'b0;
    end else begin
      count <= count + CNT_W'(accept) - CNT_W'(fire);
      for (int i = 0; i < DEPTH; i++) begin
        if (fire && IDX_W'(i) >= pick_idx) begin
          q_ent[i] <= up_ent[i];
          q_age[i] <= up_age[i];
        end else if (fire) begin
          q_age[i] <= q_age[i] + AGE_W'(q_age[i] != '1);
        end
        if (accept && CNT_W'(i) == wr_pos) begin
          q_ent[i] <= new_ent;
          q_age[i] <= '0;
        end
      end
      if (fire) begin
        last_vld <= 1'b1;
        last_bg  <= out_bg;
        last_wr  <= out_write;
      end
    end
  end
endmodule

// File: rtl/rq_checks.sv
`timescale 1ns/1ps
module rq_checks #(
  parameter int DEPTH = 64,
  parameter int BG_W = 2,
  parameter int BK_W = 2,
  parameter int ROW_W = 14,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NBANK = 1 << (BG_W + BK_W)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic                        out_need_act,
  input logic                        cfg_closed_page,
  input logic [BG_W-1:0]             out_bg,
  input logic [BK_W-1:0]             out_bank,
  input logic [ROW_W-1:0]            out_row,
  input logic [CNT_W-1:0]            count,
  input logic                        any_hit_elig,
  input logic                        any_starved_elig,
  input logic [NBANK-1:0]            open_vld,
  input logic [NBANK-1:0][ROW_W-1:0] open_row
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !in_ready); // R11

  AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_valid && out_ready)) |=> count == $past(count) + 1'b1); // R11

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_valid); // R1

  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && any_hit_elig && !any_starved_elig) |-> !out_need_act); // R2

  AST_CLOSED_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && cfg_closed_page) |=> !open_vld[$past({out_bg, out_bank})]); // R7

  AST_OPEN_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !cfg_closed_page) |=>
      (open_vld[$past({out_bg, out_bank})] && open_row[$past({out_bg, out_bank})] == $past(out_row))); // R12
endmodule

bind bank_reorder_queue rq_checks #(.DEPTH(DEPTH), .BG_W(BG_W), .BK_W(BK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_need_act(out_need_act), .cfg_closed_page(cfg_closed_page),
  .out_bg(out_bg), .out_bank(out_bank), .out_row(out_row), .count(count),
  .any_hit_elig(any_hit_elig), .any_starved_elig(any_starved_elig),
  .open_vld(open_vld), .open_row(open_row));

// File: tb/sim_bank_reorder_queue.sv
`timescale 1ns/1ps
module sim_bank_reorder_queue;
  localparam int DEPTH = 8;
  localparam int ID_W = 2;
  localparam int BG_W = 1;
  localparam int BK_W = 1;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int AGE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_coherent = 1'b0, cfg_closed_page = 1'b0;
  logic [AGE_W-1:0] cfg_age_limit = 4'd15;
  logic in_valid = 1'b0, in_ready, in_write = 1'b0;
  logic [ID_W-1:0] in_id = '0;
  logic [BG_W-1:0] in_bg = '0;
  logic [BK_W-1:0] in_bank = '0;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic out_valid, out_ready = 1'b0, out_write, out_need_pre, out_need_act, out_autopre;
  logic [ID_W-1:0] out_id;
  logic [BG_W-1:0] out_bg;
  logic [BK_W-1:0] out_bank;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bank_reorder_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .BG_W(BG_W), .BK_W(BK_W), .ROW_W(ROW_W),
                       .COL_W(COL_W), .AGE_W(AGE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_coherent(cfg_coherent), .cfg_closed_page(cfg_closed_page),
    .cfg_age_limit(cfg_age_limit), .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
    .in_write(in_write), .in_bg(in_bg), .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_write(out_write),
    .out_bg(out_bg), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .out_need_pre(out_need_pre), .out_need_act(out_need_act), .out_autopre(out_autopre));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input int id, input int wr, input int bg, input int bk, input int row,
                      input int col);
    @(negedge clk);
    in_id = ID_W'(id); in_write = wr[0]; in_bg = BG_W'(bg); in_bank = BK_W'(bk);
    in_row = ROW_W'(row); in_col = COL_W'(col); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // sample the selection before the edge, then take it
  task automatic pop(input string req, input int col, input int act, input int pre);
    chk(req, int'(out_valid), 1);
    chk(req, int'(out_col), col);
    chk(req, int'(out_need_act), act);
    chk(req, int'(out_need_pre), pre);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 empty", int'(out_valid), 0);
    chk("R1 ready", int'(in_ready), 1);

    // R2 hit over bank-group change; R12 table written at issue edge
    push(0, 0, 0, 0, 3, 1);
    pop("R4 first access activates idle bank", 1, 1, 0);
    push(1, 0, 1, 0, 5, 2);
    push(2, 0, 0, 0, 3, 3);
    pop("R2 hit wins", 3, 0, 0);
    pop("R12 other bank", 2, 1, 0);

    // R3 bank-group alternation
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R3 setup", 1, 1, 0);
    push(1, 0, 0, 1, 1, 2);
    push(2, 0, 1, 1, 1, 3);
    pop("R3 other group first", 3, 1, 0);
    pop("R3 same group later", 2, 1, 0);

    // R4 idle over conflicting row
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R4 setup a", 1, 1, 0);
    push(1, 0, 1, 0, 1, 2);
    pop("R4 setup b", 2, 1, 0);
    push(2, 0, 0, 0, 7, 3);
    push(3, 0, 0, 1, 7, 4);
    pop("R4 idle bank first", 4, 1, 0);
    pop("R4 conflict needs precharge", 3, 1, 1);

    // R8 direction grouping, R1 initial direction is read
    do_reset();
    push(0, 1, 0, 0, 1, 1);
    push(1, 0, 0, 1, 1, 2);
    pop("R8 read first after reset", 2, 1, 0);
    pop("R8 write", 1, 1, 0);
    push(2, 0, 1, 1, 2, 3);
    push(3, 1, 1, 0, 2, 4);
    pop("R8 keep write direction", 4, 1, 0);
    pop("R8 read last", 3, 1, 0);

    // R5 same ID keeps arrival order
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R5 setup", 1, 1, 0);
    push(1, 0, 1, 1, 5, 2);
    push(1, 0, 0, 0, 1, 3);
    pop("R5 older same id first", 2, 1, 0);
    pop("R5 hit after", 3, 0, 0);

    // R6 coherency off: younger read hit passes older write
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R6 setup off", 1, 1, 0);
    push(1, 1, 0, 0, 1, 2);
    push(2, 0, 0, 0, 1, 3);
    pop("R6 off allows pass", 3, 0, 0);
    pop("R6 off write", 2, 0, 0);
    // R6 coherency on
    cfg_coherent = 1'b1;
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R6 setup on", 1, 1, 0);
    push(1, 1, 0, 0, 1, 2);
    push(2, 0, 0, 0, 1, 3);
    pop("R6 on keeps order", 2, 0, 0);
    pop("R6 on read", 3, 0, 0);
    cfg_coherent = 1'b0;

    // R7 closed page
    cfg_closed_page = 1'b1;
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    chk("R7 autopre", int'(out_autopre), 1);
    pop("R7 first", 1, 1, 0);
    push(1, 0, 0, 0, 1, 2);
    pop("R7 bank closed again", 2, 1, 0);
    cfg_closed_page = 1'b0;
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    chk("R7 open page no autopre", int'(out_autopre), 0);

    // R9 age limit 2: conflict entry jumps ahead after two bypasses
    cfg_age_limit = 4'd2;
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R9 setup", 1, 1, 0);
    push(1, 0, 0, 0, 2, 2);
    push(2, 0, 0, 0, 1, 3);
    push(3, 0, 0, 0, 1, 4);
    push(0, 0, 0, 0, 1, 5);
    pop("R9 hit one", 3, 0, 0);
    pop("R9 hit two", 4, 0, 0);
    pop("R9 starved jumps", 2, 1, 1);
    pop("R9 remaining", 5, 1, 1);
    // R9 large limit: no jump
    cfg_age_limit = 4'd15;
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    pop("R9 setup b", 1, 1, 0);
    push(1, 0, 0, 0, 2, 2);
    push(2, 0, 0, 0, 1, 3);
    push(3, 0, 0, 0, 1, 4);
    push(0, 0, 0, 0, 1, 5);
    pop("R9 b hit one", 3, 0, 0);
    pop("R9 b hit two", 4, 0, 0);
    pop("R9 b hit three", 5, 0, 0);
    pop("R9 b conflict last", 2, 1, 1);

    // R10 oldest wins a tie
    do_reset();
    push(0, 0, 0, 0, 1, 1);
    push(1, 0, 0, 1, 1, 2);
    pop("R10 oldest", 1, 1, 0);
    pop("R10 next", 2, 1, 0);

    // R11 full queue back-pressure
    do_reset();
    for (int k = 0; k < DEPTH; k++) push(k % 4, 0, 0, 0, 1, k);
    chk("R11 full not ready", int'(in_ready), 0);
    push(0, 0, 1, 1, 1, 15);
    for (int k = 0; k < DEPTH; k++) pop("R11 drain order", k, (k == 0) ? 1 : 0, 0);
    chk("R11 extra not stored", int'(out_valid), 0);
    chk("R11 ready again", int'(in_ready), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule